// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Write Hold-Off

An 8-bit up-counter for a small controller. It either times on an instruction-cycle tick or counts transitions on an external pin. The active pin edge is selectable. The pin passes through a two-flop synchronizer before edge detection.

One shared divider sits in front of either this counter or a watchdog output, chosen by an ownership bit. When the watchdog owns the divider, the counter steps on every source event.

A bus write to the counter loads it and freezes counting for the next two instruction ticks. When the count rolls from 255 to 0, a sticky overflow flag is set. An interrupt request is driven while both the flag and its enable bit are 1. Software reads and writes three registers through a simple write strobe and a combinational read port.

Top module: `cnt8_timer`

## Requirements
- R1: Address 0 holds the count. A write there loads `wr_data` into it, and a read returns the current value.
- R2: Address 1 holds the configuration, and a read returns it with bits 7:6 at zero. The fields are:
  - bit 0: source, 0 = instruction tick, 1 = pin.
  - bit 1: edge, 0 = low-to-high, 1 = high-to-low.
  - bit 2: divider owner, 1 = watchdog, 0 = counter.
  - bits 5:3: rate code.
- R3: With source 0 the count steps only on `cyc_tick`, and pin activity has no effect. With source 1 the count steps only on pin edges, and `cyc_tick` has no effect.
- R4: In pin mode the pin passes through two synchronizer flops. Edge 0 counts rising transitions and edge 1 counts falling ones. Each transition adds exactly one, visible at most four clocks after the pin changes.
- R5: With the divider owned by the counter, the count steps once per 2^(code+1) source events. Code 0 gives 1:2 and code 7 gives 1:256.
- R6: With the divider owned by the watchdog, the count steps on every source event. In that case `wdt_tick` pulses once per 2^(code+1) instruction ticks. With the divider owned by the counter, `wdt_tick` equals `cyc_tick`.
- R7: After a count write, the next two instruction ticks cause no increment. In undivided timer mode, loading 258−N therefore sets the flag on the Nth tick.
- R8: A count write clears the divider's accumulated events when the counter owns the divider.
- R9: The roll from 255 to 0 sets the overflow flag. The flag then stays at 1 while counting continues, until software writes status bit 0.
- R10: Address 2 is status, with bit 0 = overflow flag and bit 1 = interrupt enable. `irq` is 1 exactly when both bits are 1.
- R11: After reset, count, configuration, status, `ovf_flag` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse per instruction cycle |
| ext_pin | input | 1 | Asynchronous external count input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 count, 1 config, 2 status) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |
| wdt_tick | output | 1 | Event stream handed to the watchdog |

## Verification
The bench builds the block with its default parameters: an 8-bit count, a 3-bit rate code and a two-tick hold-off. At these values a strided sweep of load values can be run all the way to overflow, giving the 258−N relation at many points. Every one of the eight divide ratios can also be timed to overflow against the formula 6·2^(code+1), plus two extra ticks at 1:2 where the first divided event falls inside the hold-off. The watchdog stream is counted over a 128-tick window for each ratio up to 1:128. The pin is driven with single transitions under both edge settings.

// File: rtl/cnt8_pkg.sv
// Package: register addresses and configuration layout shared by the timer.
// Assumes a 2-bit register address space.
package cnt8_pkg;
    localparam int ADDR_W = 2;
    localparam int RATE_W = 3;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_CFG   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;

    // Configuration register, ext_src in bit 0.
    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              wdg_owns_ps;
        logic              fall_edge;
        logic              ext_src;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
endpackage

// File: rtl/cnt8_src_sel.sv
// Source selection: synchronizes the external pin, detects the chosen
// edge and picks between pin events and the instruction tick.
// Assumes SYNC_STAGES >= 2 and cyc_tick is already synchronous.
module cnt8_src_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic cyc_tick,
    input  logic ext_src,
    input  logic fall_edge,
    output logic src_tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pin_s;
    logic                   rise_ev;
    logic                   fall_ev;

    // First synchronizer flop samples the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= ext_pin;
    end

    // Remaining synchronizer flops form a chain.
    for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q[g] <= 1'b0;
            else        sync_q[g] <= sync_q[g-1];
        end
    end

    assign pin_s = sync_q[SYNC_STAGES-1];

    // Holds the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    // Edge detection and source multiplexing.
    always_comb begin
        rise_ev  = pin_s & ~prev_q;
        fall_ev  = ~pin_s & prev_q;
        src_tick = ext_src ? (fall_edge ? fall_ev : rise_ev) : cyc_tick;
    end

    // Pin-mode events are single-cycle pulses under a fixed polarity.
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_src && src_tick) |=> !(ext_src && src_tick && $stable(fall_edge) && $stable(ext_src))) else $error("edge pulse repeated"); // R4
endmodule

// File: rtl/cnt8_prescaler.sv
// Shared power-of-two divider: emits one pulse per 2^(rate+1) input events.
// Assumes clr and in_tick are synchronous; clr wins over in_tick.
module cnt8_prescaler #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_tick,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    output logic              out_tick
);
    localparam int PS_W = 1 << RATE_W;

    logic [PS_W-1:0] ps_q;
    logic [PS_W-1:0] mask;

    // Builds the mask of low bits that must all be ones for a pulse.
    always_comb begin
        mask = '0;
        for (int i = 0; i < PS_W; i++) begin
            if (i <= int'(rate)) mask[i] = 1'b1;
        end
        out_tick = in_tick && ((ps_q & mask) == mask);
    end

    // Event accumulator: cleared on request, else advances per input event.
    always_ff @(posedge clk) begin
        if (!rst_n)       ps_q <= '0;
        else if (clr)     ps_q <= '0;
        else if (in_tick) ps_q <= ps_q + 1'b1;
    end

    AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ps_q == '0)) else $error("divider not cleared"); // R8
    AST_PS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_tick && !clr) |=> (ps_q == $past(ps_q) + 1'b1)) else $error("divider did not advance"); // R5
endmodule

// File: rtl/cnt8_counter.sv
// Count register with post-write hold-off and sticky overflow flag.
// Assumes inc_tick already reflects source and divider choice; the
// hold-off is measured in instruction ticks.
module cnt8_counter #(
    parameter int W   = 8,
    parameter int INH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_tick,
    input  logic         inc_tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         flag_wr,
    input  logic         flag_val,
    output logic [W-1:0] count,
    output logic         flag
);
    localparam int          IW  = $clog2(INH + 1);
    localparam logic [W-1:0] MAX = '1;

    logic [IW-1:0] inh_q;
    logic          step;

    // An increment is allowed only outside the hold-off and not during a load.
    always_comb step = inc_tick && (inh_q == '0) && !load;

    // Hold-off counter: reloaded on a write, drained by instruction ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)                          inh_q <= '0;
        else if (load)                       inh_q <= IW'(INH);
        else if (cyc_tick && inh_q != '0)    inh_q <= inh_q - 1'b1;
    end

    // Count register: load has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (step) count <= count + 1'b1;
    end

    // Overflow flag: set by the roll to zero, otherwise written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag <= 1'b0;
        else if (step && count == MAX)  flag <= 1'b1;
        else if (flag_wr)               flag <= flag_val;
    end

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val))) else $error("load lost"); // R1
    AST_HOLDOFF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q != '0 && !load) |=> (count == $past(count))) else $error("count moved in hold-off"); // R7
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_tick && inh_q == '0 && !load && count == MAX) |=> (flag && count == '0)) else $error("wrap missed"); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_wr) |=> flag) else $error("flag dropped"); // R9
endmodule

// File: rtl/cnt8_timer.sv
// Top level: register file, divider ownership routing and interrupt gating.
// Assumes a single-cycle write strobe and a combinational read port.
module cnt8_timer
    import cnt8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int INHIBIT_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_tick,
    input  logic              ext_pin,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              ovf_flag,
    output logic              irq,
    output logic              wdt_tick
);
    cfg_t             cfg_q;
    logic             irq_en_q;
    logic             src_tick;
    logic             ps_in;
    logic             ps_out;
    logic             ps_clr;
    logic             cnt_inc;
    logic             wr_cnt;
    logic             wr_cfg;
    logic             wr_stat;
    logic [CNT_W-1:0] count;

    // Write decode.
    always_comb begin
        wr_cnt  = wr_en && (wr_addr == A_COUNT);
        wr_cfg  = wr_en && (wr_addr == A_CFG);
        wr_stat = wr_en && (wr_addr == A_STAT);
    end

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= cfg_t'(wr_data[CFG_W-1:0]);
    end

    // Interrupt enable bit of the status register.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_en_q <= 1'b0;
        else if (wr_stat) irq_en_q <= wr_data[1];
    end

    cnt8_src_sel #(.SYNC_STAGES(SYNC_STAGES)) src_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .cyc_tick  (cyc_tick),
        .ext_src   (cfg_q.ext_src),
        .fall_edge (cfg_q.fall_edge),
        .src_tick  (src_tick)
    );

    // Divider ownership routing between counter and watchdog.
    always_comb begin
        ps_in    = cfg_q.wdg_owns_ps ? cyc_tick : src_tick;
        ps_clr   = wr_cnt && !cfg_q.wdg_owns_ps;
        cnt_inc  = cfg_q.wdg_owns_ps ? src_tick : ps_out;
        wdt_tick = cfg_q.wdg_owns_ps ? ps_out : cyc_tick;
    end

    cnt8_prescaler #(.RATE_W(RATE_W)) ps_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_tick  (ps_in),
        .clr      (ps_clr),
        .rate     (cfg_q.rate),
        .out_tick (ps_out)
    );

    cnt8_counter #(.W(CNT_W), .INH(INHIBIT_CYC)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_tick (cyc_tick),
        .inc_tick (cnt_inc),
        .load     (wr_cnt),
        .load_val (wr_data),
        .flag_wr  (wr_stat),
        .flag_val (wr_data[0]),
        .count    (count),
        .flag     (ovf_flag)
    );

    // Interrupt gating and read multiplexer.
    always_comb begin
        irq = ovf_flag && irq_en_q;
        case (rd_addr)
            A_COUNT: rd_data = count;
            A_CFG:   rd_data = CNT_W'(cfg_q);
            A_STAT:  rd_data = CNT_W'({irq_en_q, ovf_flag});
            default: rd_data = '0;
        endcase
    end

    AST_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !wr_data[1]) |=> !irq) else $error("irq while disabled"); // R10
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable(cfg_q)) else $error("config changed"); // R2
endmodule

// File: tb/cnt8_timer_tb_top.sv
module cnt8_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       ext_pin = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ovf_flag, irq, wdt_tick;
    int checks = 0;
    int errors = 0;
    int tdiv = 0;
    int v;

    always #4 clk = ~clk;

    // Instruction tick: one clock in four, driven on the falling edge.
    always @(negedge clk) begin
        tdiv     <= (tdiv + 1) % 4;
        cyc_tick <= (tdiv == 3);
    end

    cnt8_timer dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ext_pin(ext_pin),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .ovf_flag(ovf_flag), .irq(irq), .wdt_tick(wdt_tick)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int val);
        @(negedge clk);
        rd_addr = a;
        #1 val = int'(rd_data);
    endtask

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (cyc_tick) k++;
        end
        @(negedge clk);
    endtask

    task automatic ticks_to_ovf(output int n);
        logic t;
        n = 0;
        while (n < 5000) begin
            @(posedge clk);
            t = cyc_tick;
            @(negedge clk);
            if (t) n++;
            if (ovf_flag) break;
        end
    endtask

    task automatic count_wdt(input int window, output int pulses);
        int k = 0;
        pulses = 0;
        while (k < window) begin
            @(posedge clk);
            #2;
            if (cyc_tick) k++;
            if (wdt_tick) pulses++;
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(2'd0, v); check("R11 count", v, 0);
        rd(2'd1, v); check("R11 cfg", v, 0);
        rd(2'd2, v); check("R11 status", v, 0);
        check("R11 ovf_flag", int'(ovf_flag), 0);
        check("R11 irq", int'(irq), 0);

        // R2 config readback masks upper bits
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R2 cfg readback", v, 8'h3F);

        // R1 load and read, R7 hold-off, undivided timer mode (owner = watchdog)
        wr(2'd1, 8'h04);
        wr(2'd0, 8'h20);
        rd(2'd0, v); check("R1 count load", v, 8'h20);
        wait_ticks(2);
        rd(2'd0, v); check("R7 frozen for two ticks", v, 8'h20);
        // R3 pin toggling ignored in timer mode
        fork
            begin
                repeat (24) @(negedge clk) ext_pin = ~ext_pin;
            end
        join_none
        wait_ticks(8);
        rd(2'd0, v); check("R3 timer ignores pin", v, 8'h28);
        ext_pin = 1'b0;
        repeat (4) @(negedge clk);

        // R7 sweep: loading V overflows after 258-V ticks
        for (int lv = 0; lv < 256; lv += 15) begin
            wr(2'd2, 8'h00);
            wr(2'd0, 8'(lv));
            ticks_to_ovf(n);
            check("R7 ticks to overflow", n, 258 - lv);
        end

        // R9 flag stays set while counting continues
        wait_ticks(5);
        check("R9 flag sticky", int'(ovf_flag), 1);
        rd(2'd2, v); check("R10 status with enable off", v, 1);
        check("R10 irq off when disabled", int'(irq), 0);
        wr(2'd2, 8'h03);
        check("R10 irq on", int'(irq), 1);
        wr(2'd2, 8'h02);
        check("R9 flag cleared by write", int'(ovf_flag), 0);
        check("R10 irq off after clear", int'(irq), 0);
        wr(2'd2, 8'h00);

        // R5 and R8: divider owned by counter, every rate
        for (int r = 0; r < 8; r++) begin
            int d;
            d = 1 << (r + 1);
            wr(2'd1, 8'(r << 3));
            wr(2'd2, 8'h00);
            wr(2'd0, 8'd250);
            ticks_to_ovf(n);
            check("R5 R8 divided overflow", n, d * 6 + ((d == 2) ? 2 : 0));
        end

        // R6 watchdog stream when counter owns divider
        wr(2'd1, 8'h00);
        count_wdt(64, p);
        check("R6 wdt mirrors tick", p, 64);
        // R6 watchdog stream when watchdog owns divider
        for (int r = 0; r < 7; r++) begin
            wr(2'd1, 8'(8'h04 | (r << 3)));
            count_wdt(128, p);
            check("R6 wdt divided", p, 128 >> (r + 1));
        end

        // R4 pin mode, rising edge, undivided
        wr(2'd1, 8'h05);
        wr(2'd0, 8'h10);
        wait_ticks(3);
        @(negedge clk) ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd0, v); check("R4 rising counted", v, 8'h11);
        @(negedge clk) ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, v); check("R4 falling ignored in rising mode", v, 8'h11);
        wait_ticks(6);
        rd(2'd0, v); check("R3 pin mode ignores tick", v, 8'h11);
        // R4 falling edge mode
        wr(2'd1, 8'h07);
        @(negedge clk) ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        rd(2'd0, v); check("R4 rising ignored in falling mode", v, 8'h11);
        @(negedge clk) ext_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, v); check("R4 falling counted", v, 8'h12);
        // R4 burst of pulses
        wr(2'd1, 8'h05);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) ext_pin = 1'b1;
            repeat (5) @(negedge clk);
            ext_pin = 1'b0;
            repeat (5) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        rd(2'd0, v); check("R4 burst count", v, 8'h12 + 10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule